// File: doc/BRIEF.md
# Debug Trigger State Sequencer

This block is the sequencing heart of an on-chip debug unit. Software arms it, and it then steps through up to three armed states as trigger events come in. It ends in a disarmed state, which may raise a breakpoint request and tells the trace logic to close the session. The address comparators, the trace storage and the instruction pipeline sit outside the block. Their results arrive as single-cycle input pulses. Forced hits are reported when the address matches, and tag hits when a tagged instruction executes. Because of this, a tag hit for an address normally arrives several cycles after the forced hit for the same address.

A single configuration vector gives every armed state its own routing fields. Each field names the next state for each routed trigger kind: immediate write, tag hit and forced hit. Two sources bypass that routing and always disarm. The first is an external tag, accepted only in emulation mode. The second is a coprocessor software breakpoint request, accepted only when its enable is set. When several events coincide, a fixed priority picks one winner. Sticky status flags record which event moved the sequencer, and they stay set until the next arm.

Top module: `dbg_seq_top`

## Requirements
- R1: After reset, `state_o` is 0, and `armed_o`, `flags_o`, `bkpt_o`, `bkpt_dbg_o` and `trace_end_o` are all 0.
- R2: In state 0, a pulse on `arm_i` moves the sequencer to state 1 on the next edge, sets `armed_o` and clears `flags_o`. In state 0, every trigger input is ignored. While armed, `arm_i` is ignored.
- R3: In armed state s (1..3), a winning routed trigger of kind k moves the sequencer to the 2-bit state in `route_cfg_i[((s-1)*3+k)*2 +: 2]`. The kind codes are k=0 for immediate, k=1 for tag hit and k=2 for forced hit.
- R4: A winning forced hit ORs `force_hit_i` into `flags_o[NCMP-1:0]`. A winning tag hit ORs `tag_hit_i` into `flags_o[2*NCMP-1:NCMP]`.
- R5: Events in the same cycle are resolved in this order: coprocessor request, external tag, immediate trigger, tag hit, forced hit. Only the winner sets flags and decides the next state.
- R6: While armed, `ext_tag_i` with `emul_mode_i` high moves the sequencer to state 0 and sets `flags_o[2*NCMP]`. It raises a breakpoint only if `bkpt_en_i` is high. With `emul_mode_i` low, `ext_tag_i` has no effect.
- R7: While armed, `cop_req_i` with `cop_en_i` high moves the sequencer to state 0, sets `flags_o[2*NCMP+2]` and raises a breakpoint whatever the value of `bkpt_en_i`. With `cop_en_i` low, the request has no effect.
- R8: An immediate trigger that wins sets `flags_o[2*NCMP+1]`.
- R9: Every move from an armed state to state 0 pulses `trace_end_o` and clears `armed_o`. A routed move to state 0 raises a breakpoint only when `bkpt_en_i` is high.
- R10: `bkpt_o` is high for exactly one cycle per breakpoint. In that cycle, `bkpt_dbg_o` equals the `brk_to_dbg_i` value from the trigger cycle, where 1 means debug mode and 0 means software interrupt.
- R11: Flags are sticky: once set, a flag stays set until the next arm from state 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| route_cfg_i | input | 18 | Per-state next-state fields |
| arm_i | input | 1 | Arm pulse, acted on in state 0 only |
| imm_trig_i | input | 1 | Immediate trigger write pulse |
| force_hit_i | input | NCMP | Forced comparator hits |
| tag_hit_i | input | NCMP | Tag hits at execution |
| ext_tag_i | input | 1 | External tag reached execution |
| emul_mode_i | input | 1 | Emulation mode, qualifies external tags |
| cop_req_i | input | 1 | Coprocessor software breakpoint request |
| cop_en_i | input | 1 | Coprocessor breakpoint enable |
| bkpt_en_i | input | 1 | Breakpoint enable for routed and external disarm |
| brk_to_dbg_i | input | 1 | Breakpoint kind: 1 debug mode, 0 software interrupt |
| state_o | output | 2 | Current sequencer state |
| armed_o | output | 1 | Arm bit |
| flags_o | output | 2*NCMP+3 | Sticky status flags |
| bkpt_o | output | 1 | Breakpoint request pulse |
| bkpt_dbg_o | output | 1 | Kind of the breakpoint now requested |
| trace_end_o | output | 1 | Trace session terminate pulse |

## Verification
Every result is registered exactly once. A trigger presented before edge N changes `state_o`, `armed_o`, `flags_o`, `bkpt_o`, `bkpt_dbg_o` and `trace_end_o` at edge N. The pulse outputs fall again at edge N+1. The bench drives inputs on the falling edge and holds them across one rising edge. It samples on the next falling edge, then removes the stimulus. For the one-cycle pulse checks, it waits one more cycle and samples `bkpt_o` and `trace_end_o` again.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;
  localparam int STW        = 2;
  localparam int NUM_ARMED  = 3;
  localparam int NUM_ROUTED = 3;
  localparam int ROUTE_W    = NUM_ARMED * NUM_ROUTED * STW;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ONE  = 2'd1,
    ST_TWO  = 2'd2,
    ST_THR  = 2'd3
  } seq_state_t;

  typedef enum logic [2:0] {
    TK_NONE  = 3'd0,
    TK_COP   = 3'd1,
    TK_EXT   = 3'd2,
    TK_IMM   = 3'd3,
    TK_TAG   = 3'd4,
    TK_FORCE = 3'd5
  } trig_kind_t;

  // fixed priority: coprocessor, external tag, immediate, tag hit, forced hit
  function automatic trig_kind_t prio_pick(input logic cop, input logic ext,
                                           input logic imm, input logic tag,
                                           input logic frc);
    if (cop)      return TK_COP;
    else if (ext) return TK_EXT;
    else if (imm) return TK_IMM;
    else if (tag) return TK_TAG;
    else if (frc) return TK_FORCE;
    return TK_NONE;
  endfunction

  // column of a routed kind inside one state's routing group
  function automatic logic [1:0] route_col(input trig_kind_t k);
    case (k)
      TK_TAG:   return 2'd1;
      TK_FORCE: return 2'd2;
      default:  return 2'd0;
    endcase
  endfunction

  function automatic logic [STW-1:0] cfg_field(input logic [ROUTE_W-1:0] cfg,
                                               input int s, input int k);
    return cfg[((s - 1) * NUM_ROUTED + k) * STW +: STW];
  endfunction
endpackage

// File: rtl/dbg_trig_arb.sv
module dbg_trig_arb
  import dbg_seq_pkg::*;
#(
  parameter int NCMP = 4
) (
  input  logic            en_i,
  input  logic            cop_req_i,
  input  logic            cop_en_i,
  input  logic            ext_tag_i,
  input  logic            emul_mode_i,
  input  logic            imm_i,
  input  logic [NCMP-1:0] tag_hit_i,
  input  logic [NCMP-1:0] force_hit_i,
  output trig_kind_t      kind_o
);
  logic cop_ok, ext_ok, tag_any, frc_any;

  assign cop_ok  = en_i & cop_req_i & cop_en_i;
  assign ext_ok  = en_i & ext_tag_i & emul_mode_i;
  assign tag_any = en_i & (|tag_hit_i);
  assign frc_any = en_i & (|force_hit_i);

  assign kind_o = prio_pick(cop_ok, ext_ok, en_i & imm_i, tag_any, frc_any);
endmodule

// File: rtl/dbg_route_sel.sv
module dbg_route_sel
  import dbg_seq_pkg::*;
(
  input  logic [ROUTE_W-1:0] cfg_i,
  input  seq_state_t         cur_i,
  input  logic [1:0]         col_i,
  output seq_state_t         nxt_o
);
  logic [STW-1:0] per_state [NUM_ARMED+1];

  assign per_state[0] = ST_IDLE;

  for (genvar s = 1; s <= NUM_ARMED; s++) begin : g_state
    logic [STW-1:0] cols [NUM_ROUTED];
    for (genvar k = 0; k < NUM_ROUTED; k++) begin : g_col
      assign cols[k] = cfg_field(cfg_i, s, k);
    end
    assign per_state[s] = (col_i == 2'd1) ? cols[1] :
                          (col_i == 2'd2) ? cols[2] : cols[0];
  end

  assign nxt_o = seq_state_t'(per_state[cur_i]);
endmodule

// File: rtl/dbg_flag_reg.sv
module dbg_flag_reg #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] flags_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flags_o <= '0;
    else if (clr_i) flags_o <= '0;
    else            flags_o <= flags_o | set_i;
  end
endmodule

// File: rtl/dbg_seq_top.sv
module dbg_seq_top
  import dbg_seq_pkg::*;
#(
  parameter int NCMP = 4,
  localparam int FW  = 2 * NCMP + 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ROUTE_W-1:0] route_cfg_i,
  input  logic               arm_i,
  input  logic               imm_trig_i,
  input  logic [NCMP-1:0]    force_hit_i,
  input  logic [NCMP-1:0]    tag_hit_i,
  input  logic               ext_tag_i,
  input  logic               emul_mode_i,
  input  logic               cop_req_i,
  input  logic               cop_en_i,
  input  logic               bkpt_en_i,
  input  logic               brk_to_dbg_i,
  output logic [1:0]         state_o,
  output logic               armed_o,
  output logic [FW-1:0]      flags_o,
  output logic               bkpt_o,
  output logic               bkpt_dbg_o,
  output logic               trace_end_o
);
  localparam int F_EXT = 2 * NCMP;
  localparam int F_IMM = 2 * NCMP + 1;
  localparam int F_COP = 2 * NCMP + 2;

  seq_state_t state_q, state_d, routed_nxt;
  trig_kind_t trig_kind;
  logic       seq_live;
  logic       arm_take;
  logic       end_sess;
  logic       brk_req;
  logic [FW-1:0] flag_set;

  assign seq_live = (state_q != ST_IDLE);
  assign arm_take = ~seq_live & arm_i;

  dbg_trig_arb #(.NCMP(NCMP)) u_arb (
    .en_i        (seq_live),
    .cop_req_i   (cop_req_i),
    .cop_en_i    (cop_en_i),
    .ext_tag_i   (ext_tag_i),
    .emul_mode_i (emul_mode_i),
    .imm_i       (imm_trig_i),
    .tag_hit_i   (tag_hit_i),
    .force_hit_i (force_hit_i),
    .kind_o      (trig_kind)
  );

  dbg_route_sel u_route (
    .cfg_i (route_cfg_i),
    .cur_i (state_q),
    .col_i (route_col(trig_kind)),
    .nxt_o (routed_nxt)
  );

  always_comb begin
    state_d  = state_q;
    end_sess = 1'b0;
    brk_req  = 1'b0;
    flag_set = '0;
    if (arm_take) begin
      state_d = ST_ONE;
    end else begin
      case (trig_kind)
        TK_COP: begin
          state_d         = ST_IDLE;
          end_sess        = 1'b1;
          brk_req         = 1'b1;
          flag_set[F_COP] = 1'b1;
        end
        TK_EXT: begin
          state_d         = ST_IDLE;
          end_sess        = 1'b1;
          brk_req         = bkpt_en_i;
          flag_set[F_EXT] = 1'b1;
        end
        TK_IMM, TK_TAG, TK_FORCE: begin
          state_d  = routed_nxt;
          end_sess = (routed_nxt == ST_IDLE);
          brk_req  = (routed_nxt == ST_IDLE) & bkpt_en_i;
          if (trig_kind == TK_IMM)      flag_set[F_IMM] = 1'b1;
          else if (trig_kind == TK_TAG) flag_set[2*NCMP-1:NCMP] = tag_hit_i;
          else                          flag_set[NCMP-1:0] = force_hit_i;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      armed_o     <= 1'b0;
      bkpt_o      <= 1'b0;
      bkpt_dbg_o  <= 1'b0;
      trace_end_o <= 1'b0;
    end else begin
      state_q     <= state_d;
      bkpt_o      <= brk_req;
      trace_end_o <= end_sess;
      if (arm_take)      armed_o <= 1'b1;
      else if (end_sess) armed_o <= 1'b0;
      if (brk_req)       bkpt_dbg_o <= brk_to_dbg_i;
      else               bkpt_dbg_o <= 1'b0;
    end
  end

  dbg_flag_reg #(.W(FW)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (arm_take),
    .set_i   (flag_set),
    .flags_o (flags_o)
  );

  assign state_o = state_q;
endmodule

// File: rtl/dbg_seq_chk.sv
module dbg_seq_chk #(
  parameter int NCMP = 4,
  localparam int FW  = 2 * NCMP + 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            arm_i,
  input logic            imm_trig_i,
  input logic [NCMP-1:0] force_hit_i,
  input logic [NCMP-1:0] tag_hit_i,
  input logic            ext_tag_i,
  input logic            emul_mode_i,
  input logic            cop_req_i,
  input logic            cop_en_i,
  input logic [1:0]      state_o,
  input logic            armed_o,
  input logic [FW-1:0]   flags_o,
  input logic            bkpt_o,
  input logic            trace_end_o
);
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0 && !arm_i) |=> (state_o == 2'd0));

  p_ext_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != 2'd0 && ext_tag_i && !emul_mode_i && !cop_req_i && !imm_trig_i
     && tag_hit_i == '0 && force_hit_i == '0) |=> $stable(state_o));

  p_cop_disarm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != 2'd0 && cop_req_i && cop_en_i) |=>
      (state_o == 2'd0 && bkpt_o && trace_end_o));

  p_end_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trace_end_o |-> (state_o == 2'd0 && !armed_o));

  p_bkpt_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bkpt_o |=> !bkpt_o);

  p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(state_o == 2'd0 && arm_i) |=> ((flags_o & $past(flags_o)) == $past(flags_o)));
endmodule

bind dbg_seq_top dbg_seq_chk #(.NCMP(NCMP)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .arm_i       (arm_i),
  .imm_trig_i  (imm_trig_i),
  .force_hit_i (force_hit_i),
  .tag_hit_i   (tag_hit_i),
  .ext_tag_i   (ext_tag_i),
  .emul_mode_i (emul_mode_i),
  .cop_req_i   (cop_req_i),
  .cop_en_i    (cop_en_i),
  .state_o     (state_o),
  .armed_o     (armed_o),
  .flags_o     (flags_o),
  .bkpt_o      (bkpt_o),
  .trace_end_o (trace_end_o)
);

// File: tb/dbg_seq_top_test.sv
module dbg_seq_top_test;
  localparam int NC = 4;
  localparam int FW = 2 * NC + 3;
  localparam int FB_EXT = 2 * NC;
  localparam int FB_IMM = 2 * NC + 1;
  localparam int FB_COP = 2 * NC + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [17:0] cfg;
  logic arm, imm, ext, emul, cop, cop_en, ben, kind;
  logic [NC-1:0] fh, th;
  logic [1:0] st;
  logic armed, bk, bkd, tend;
  logic [FW-1:0] fl;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  dbg_seq_top #(.NCMP(NC)) uut (
    .clk(clk), .rst_n(rst_n), .route_cfg_i(cfg), .arm_i(arm), .imm_trig_i(imm),
    .force_hit_i(fh), .tag_hit_i(th), .ext_tag_i(ext), .emul_mode_i(emul),
    .cop_req_i(cop), .cop_en_i(cop_en), .bkpt_en_i(ben), .brk_to_dbg_i(kind),
    .state_o(st), .armed_o(armed), .flags_o(fl), .bkpt_o(bk),
    .bkpt_dbg_o(bkd), .trace_end_o(tend)
  );

  function automatic logic [17:0] put_route(input logic [17:0] c, input int s,
                                            input int k, input logic [1:0] v);
    logic [17:0] r = c;
    r[((s - 1) * 3 + k) * 2 +: 2] = v;
    return r;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    arm = 0; imm = 0; ext = 0; cop = 0; fh = '0; th = '0;
  endtask

  // drive at falling edge, hold over one rising edge, sample at next falling edge
  task automatic step(input logic a, input logic i, input logic [NC-1:0] f,
                      input logic [NC-1:0] t, input logic e, input logic c);
    @(negedge clk);
    arm = a; imm = i; fh = f; th = t; ext = e; cop = c;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic t_reset();
    check("R1", "state", st, 0);
    check("R1", "armed", armed, 0);
    check("R1", "flags", fl, 0);
    check("R1", "bkpt", bk, 0);
    check("R1", "trace_end", tend, 0);
    check("R1", "bkpt_dbg", bkd, 0);
  endtask

  task automatic t_idle_ignore();
    cop_en = 1; emul = 1;
    step(0, 1, 4'hF, 4'hF, 1, 1);
    check("R2", "idle state", st, 0);
    check("R2", "idle flags", fl, 0);
    check("R2", "idle bkpt", bk, 0);
  endtask

  task automatic t_arm();
    step(1, 0, '0, '0, 0, 0);
    check("R2", "arm state", st, 1);
    check("R2", "armed", armed, 1);
    step(1, 0, '0, '0, 0, 0);
    check("R2", "rearm ignored", st, 1);
  endtask

  task automatic t_routing();
    logic [FW-1:0] ef;
    ben = 1; kind = 1;
    step(0, 0, 4'b0101, '0, 0, 0);
    check("R3", "force s1", st, 2);
    check("R4", "force flags", fl, 32'h5);
    step(0, 0, '0, 4'b0010, 0, 0);
    ef = 11'h5 | (11'b0010 << NC);
    check("R3", "tag s2", st, 1);
    check("R4", "tag flags", fl, ef);
    check("R11", "force flags kept", fl[NC-1:0], 5);
    step(0, 1, '0, '0, 0, 0);
    check("R3", "imm s1", st, 2);
    check("R8", "imm flag", fl[FB_IMM], 1);
    step(0, 1, '0, '0, 0, 0);
    check("R9", "imm s2 to idle", st, 0);
    check("R9", "trace_end", tend, 1);
    check("R9", "armed cleared", armed, 0);
    check("R9", "routed bkpt", bk, 1);
    check("R10", "kind dbg", bkd, 1);
    @(negedge clk);
    check("R10", "bkpt pulse ends", bk, 0);
    check("R9", "trace_end pulse ends", tend, 0);
  endtask

  task automatic t_priority();
    ben = 0; emul = 1; cop_en = 1;
    step(1, 0, '0, '0, 0, 0);
    check("R11", "flags cleared on arm", fl, 0);
    step(0, 1, 4'b1000, 4'b0001, 0, 0);
    check("R5", "imm beats tag/force", st, 2);
    check("R5", "only imm flag", fl, 1 << FB_IMM);
    step(0, 0, 4'b1000, 4'b0100, 0, 0);
    check("R5", "tag beats force", st, 1);
    check("R5", "force flags untouched", fl[NC-1:0], 0);
    step(0, 1, '0, '0, 1, 0);
    check("R6", "ext disarms", st, 0);
    check("R6", "ext flag", fl[FB_EXT], 1);
    check("R6", "ext no bkpt when disabled", bk, 0);
    check("R9", "ext trace_end", tend, 1);
    kind = 0;
    step(1, 0, '0, '0, 0, 0);
    step(0, 0, '0, '0, 1, 1);
    check("R7", "cop disarms", st, 0);
    check("R7", "cop bkpt despite disable", bk, 1);
    check("R10", "kind swi", bkd, 0);
    check("R5", "cop beats ext", fl, 1 << FB_COP);
  endtask

  task automatic t_gates();
    step(1, 0, '0, '0, 0, 0);
    emul = 0; cop_en = 0;
    step(0, 0, '0, '0, 1, 0);
    check("R6", "ext without emul", st, 1);
    check("R6", "ext without emul flags", fl, 0);
    step(0, 0, '0, '0, 0, 1);
    check("R7", "cop disabled", st, 1);
    check("R7", "cop disabled bkpt", bk, 0);
    check("R7", "cop disabled flags", fl, 0);
    // s1 tag -> 3, s3 force -> 0 with breakpoints off
    step(0, 0, '0, 4'b1000, 0, 0);
    check("R3", "tag s1", st, 3);
    ben = 0;
    step(0, 0, 4'b0010, '0, 0, 0);
    check("R3", "force s3 to idle", st, 0);
    check("R9", "no bkpt when disabled", bk, 0);
    check("R9", "trace_end", tend, 1);
    kind = 1; cop_en = 1;
    step(1, 0, '0, '0, 0, 0);
    step(0, 0, '0, '0, 0, 1);
    check("R10", "cop kind dbg", bkd, 1);
  endtask

  initial begin
    cfg = '0;
    cfg = put_route(cfg, 1, 0, 2'd2); cfg = put_route(cfg, 1, 1, 2'd3);
    cfg = put_route(cfg, 1, 2, 2'd2);
    cfg = put_route(cfg, 2, 0, 2'd0); cfg = put_route(cfg, 2, 1, 2'd1);
    cfg = put_route(cfg, 2, 2, 2'd3);
    cfg = put_route(cfg, 3, 0, 2'd0); cfg = put_route(cfg, 3, 1, 2'd2);
    cfg = put_route(cfg, 3, 2, 2'd0);
    idle_inputs();
    emul = 0; cop_en = 0; ben = 0; kind = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_idle_ignore();
    t_arm();
    t_routing();
    t_priority();
    t_gates();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule